// File: doc/BRIEF.md
# Dual-Mode Floating-Point Register File

This block is the register storage of a floating-point coprocessor: 32 storage words, each 64 bits wide. One bit of a 32-bit status word picks the view software gets. In wide mode there are 32 independent 64-bit registers. In narrow mode there are 32 single-width registers packed two to a storage word, and a double-width access covers an even/odd pair. The block has a combinational read port that returns both the single and the double view of one index. It has one write port that takes either width, and an input that writes the status word.

A status write that flips the mode bit starts a repacking sequencer. The sequencer rearranges the stored words in place so that no value is lost across the switch. When the file goes narrow, the 32 upper halves that narrow mode cannot address are parked in words 16 to 31. When it goes wide again, they are put back. The sequencer first reads every source half into a 32-entry temporary buffer, then rewrites the words one per cycle, and it holds `busy` for the whole run.

A snapshot port reads and writes whole registers in the wide layout whatever the current mode. In narrow mode each snapshot word is assembled from, or scattered to, its single-width half and its parked upper half in the same cycle. Save and restore logic therefore never has to switch modes.

Top module: `dual_fpr_file`

## Requirements
- R1: After reset the status word reads 0x34000000, so bit 26 is 1 and the file is in wide mode. `busy` is 0 and every register reads zero.
- R2: In wide mode (status bit 26 = 1), a double write to index i sets storage word i. A double read of index i returns that word.
- R3: In wide mode a single read of index i returns bits 31:0 of word i. A single write to index i replaces those bits with bits 31:0 of the write data and leaves bits 63:32 unchanged.
- R4: In narrow mode (status bit 26 = 0), a single access to index i uses word i>>1. An even i uses bits 31:0 and an odd i uses bits 63:32. Write data comes from bits 31:0.
- R5: In narrow mode a double access to index i (even or odd) uses the whole of word i>>1. The odd register of the pair is the upper half.
- R6: A status write whose bit 26 equals the current bit 26 updates the status word, keeps `busy` at 0 and leaves every register unchanged.
- R7: After a switch from wide to narrow mode, narrow single register i holds the former bits 31:0 of wide word i. The former bits 63:32 of word i stay available as the upper half of snapshot word i.
- R8: After a switch from narrow to wide mode, word i is {upper half of snapshot word i, narrow single register i}. Switching to narrow and back restores every 64-bit value.
- R9: A status write that flips bit 26 raises `busy` from the next cycle for exactly 64 cycles. While `busy` is 1, register writes, snapshot writes and status writes are ignored.
- R10: A snapshot read of index i returns wide word i in wide mode. In narrow mode it returns {parked upper half of i, narrow single register i}.
- R11: A snapshot write of index i stores data in the wide layout in both modes. Afterwards a snapshot read of i returns that data, and in narrow mode single register i returns its bits 31:0.
- R12: When a snapshot write and a register write arrive in the same cycle, only the snapshot write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| status_we | input | 1 | Status word write strobe |
| status_wdata | input | 32 | New status word; bit 26 selects the mode |
| status_q | output | 32 | Current status word |
| busy | output | 1 | Repacking in progress; writes are ignored |
| rd_idx | input | 5 | Register index for reads |
| rd_single | output | 32 | Single-width read data |
| rd_double | output | 64 | Double-width read data |
| wr_en | input | 1 | Register write strobe |
| wr_dbl | input | 1 | 1 = double-width write, 0 = single-width write |
| wr_idx | input | 5 | Register index for writes |
| wr_data | input | 64 | Write data; single writes use bits 31:0 |
| snap_idx | input | 5 | Snapshot register index |
| snap_rdata | output | 64 | Snapshot read data, wide layout |
| snap_we | input | 1 | Snapshot write strobe |
| snap_wdata | input | 64 | Snapshot write data, wide layout |

## Verification
A wrong entry in the temporary buffer, or a word rewritten before it was read, stays hidden until the next mode switch. After that switch it shows as a wrong upper or lower half at the snapshot port and the read port. The bench therefore reads all 32 snapshot words after every switch and after a full round trip. A miscounted sequencer shows at once as a `busy` pulse that is not 64 cycles long. A writes-ignored gate that leaks shows as a corrupted register at the first comparison after `busy` falls. A wrong half or pair selection shows on the very next read of the affected index.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE    = 2'd0,
    SEQ_CAPTURE = 2'd1,
    SEQ_PLACE   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/fpr_mode_ctl.sv
module fpr_mode_ctl #(
  parameter int          SW           = 32,
  parameter int          MODE_BIT     = 26,
  parameter logic [31:0] RESET_STATUS = 32'h3400_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          status_we_i,
  input  logic [SW-1:0] status_wdata_i,
  input  logic          busy_i,
  output logic [SW-1:0] status_q_o,
  output logic          wide_o,
  output logic          start_o,
  output logic          to_wide_o
);

  logic [SW-1:0] status_q;
  logic [SW-1:0] status_d;
  logic          wr_ok;

  always_comb begin
    wr_ok     = status_we_i && !busy_i;
    status_d  = wr_ok ? status_wdata_i : status_q;
    start_o   = wr_ok && (status_wdata_i[MODE_BIT] != status_q[MODE_BIT]);
    to_wide_o = status_wdata_i[MODE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RESET_STATUS[SW-1:0];
    end else if (wr_ok) begin
      status_q <= status_d;
    end
  end

  assign status_q_o = status_q;
  assign wide_o     = status_q[MODE_BIT];

  AST_STATUS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) busy_i |=> $stable(status_q)); // R9

endmodule

// File: rtl/fpr_repack_seq.sv
module fpr_repack_seq
  import fpr_pkg::*;
#(
  parameter int LOG_WORDS = 5,
  parameter int HW        = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                start_i,
  input  logic                                to_wide_i,
  input  logic [(1<<LOG_WORDS)-1:0][2*HW-1:0] words_i,
  output logic                                busy_o,
  output logic                                rp_we_o,
  output logic [LOG_WORDS-1:0]                rp_idx_o,
  output logic [2*HW-1:0]                     rp_wdata_o
);

  localparam int NW = 1 << LOG_WORDS;
  localparam int IW = LOG_WORDS;
  localparam int DW = 2 * HW;
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  seq_state_e         state_q, state_d;
  logic [IW-1:0]      cnt_q, cnt_d;
  logic               wide_q, wide_d;
  logic               cap_en;
  logic [HW-1:0]      cap_val;
  logic [NW-1:0][HW-1:0] tmp_q;

  logic [IW-1:0]      pair_idx, park_idx, even_idx, odd_idx;
  logic [DW-1:0]      pair_word, park_word;
  logic [HW-1:0]      park_half;

  // next-state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    wide_d  = wide_q;
    cap_en  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start_i) begin
          state_d = SEQ_CAPTURE;
          cnt_d   = '0;
          wide_d  = to_wide_i;
        end
      end
      SEQ_CAPTURE: begin
        cap_en = 1'b1;
        cnt_d  = cnt_q + IW'(1);
        if (cnt_q == LAST) begin
          state_d = SEQ_PLACE;
          cnt_d   = '0;
        end
      end
      SEQ_PLACE: begin
        cnt_d = cnt_q + IW'(1);
        if (cnt_q == LAST) begin
          state_d = SEQ_IDLE;
          cnt_d   = '0;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // address arithmetic shared by both phases
  always_comb begin
    pair_idx  = {1'b0, cnt_q[IW-1:1]};
    park_idx  = {1'b1, cnt_q[IW-1:1]};
    even_idx  = {cnt_q[IW-2:0], 1'b0};
    odd_idx   = {cnt_q[IW-2:0], 1'b1};
    pair_word = words_i[pair_idx];
    park_word = words_i[park_idx];
    park_half = cnt_q[0] ? park_word[DW-1:HW] : park_word[HW-1:0];
  end

  // capture: going wide takes packed singles, going narrow takes upper halves
  always_comb begin
    if (wide_q) begin
      cap_val = cnt_q[0] ? pair_word[DW-1:HW] : pair_word[HW-1:0];
    end else begin
      cap_val = words_i[cnt_q][DW-1:HW];
    end
  end

  // place: one full storage word per cycle
  always_comb begin
    rp_we_o  = (state_q == SEQ_PLACE);
    rp_idx_o = cnt_q;
    if (wide_q) begin
      rp_wdata_o = {park_half, tmp_q[cnt_q]};
    end else if (!cnt_q[IW-1]) begin
      rp_wdata_o = {words_i[odd_idx][HW-1:0], words_i[even_idx][HW-1:0]};
    end else begin
      rp_wdata_o = {tmp_q[odd_idx], tmp_q[even_idx]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      wide_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wide_q  <= wide_d;
    end
  end

  for (genvar e = 0; e < NW; e++) begin : g_tmp
    always_ff @(posedge clk) begin
      if (cap_en && (cnt_q == IW'(e))) begin
        tmp_q[e] <= cap_val;
      end
    end
  end

  assign busy_o = (state_q != SEQ_IDLE);

  AST_BUSY_AFTER_FLIP: assert property (@(posedge clk) disable iff (!rst_n) start_i |=> busy_o); // R9
  AST_BUSY_HAS_CAUSE:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy_o) |-> $past(start_i)); // R9
  AST_NO_START_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> !start_i); // R9

endmodule

// File: rtl/fpr_store.sv
module fpr_store #(
  parameter int LOG_WORDS = 5,
  parameter int HW        = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wide_i,
  input  logic                                busy_i,
  input  logic                                wr_en_i,
  input  logic                                wr_dbl_i,
  input  logic [LOG_WORDS-1:0]                wr_idx_i,
  input  logic [2*HW-1:0]                     wr_data_i,
  input  logic                                snap_we_i,
  input  logic [LOG_WORDS-1:0]                snap_idx_i,
  input  logic [2*HW-1:0]                     snap_wdata_i,
  input  logic                                rp_we_i,
  input  logic [LOG_WORDS-1:0]                rp_idx_i,
  input  logic [2*HW-1:0]                     rp_wdata_i,
  input  logic [LOG_WORDS-1:0]                rd_idx_i,
  output logic [HW-1:0]                       rd_single_o,
  output logic [2*HW-1:0]                     rd_double_o,
  output logic [2*HW-1:0]                     snap_rdata_o,
  output logic [(1<<LOG_WORDS)-1:0][2*HW-1:0] words_o
);

  localparam int NW = 1 << LOG_WORDS;
  localparam int IW = LOG_WORDS;
  localparam int DW = 2 * HW;

  logic [NW-1:0][DW-1:0] word_q;
  logic [NW-1:0]         lo_we, hi_we;
  logic [NW-1:0][HW-1:0] lo_d, hi_d;

  logic [IW-1:0] wr_pair, sn_pair, sn_park, rd_pair;
  logic [DW-1:0] rd_pair_word, rd_word, sn_word, sn_pair_word, sn_park_word;

  always_comb begin
    wr_pair = {1'b0, wr_idx_i[IW-1:1]};
    sn_pair = {1'b0, snap_idx_i[IW-1:1]};
    sn_park = {1'b1, snap_idx_i[IW-1:1]};
  end

  // per-half write enables and data
  always_comb begin
    for (int w = 0; w < NW; w++) begin
      lo_we[w] = 1'b0;
      hi_we[w] = 1'b0;
      lo_d[w]  = '0;
      hi_d[w]  = '0;
    end
    if (rp_we_i) begin
      lo_we[rp_idx_i] = 1'b1;
      hi_we[rp_idx_i] = 1'b1;
      lo_d[rp_idx_i]  = rp_wdata_i[HW-1:0];
      hi_d[rp_idx_i]  = rp_wdata_i[DW-1:HW];
    end else if (!busy_i && snap_we_i) begin
      if (wide_i) begin
        lo_we[snap_idx_i] = 1'b1;
        hi_we[snap_idx_i] = 1'b1;
        lo_d[snap_idx_i]  = snap_wdata_i[HW-1:0];
        hi_d[snap_idx_i]  = snap_wdata_i[DW-1:HW];
      end else if (snap_idx_i[0]) begin
        hi_we[sn_pair] = 1'b1;
        hi_d[sn_pair]  = snap_wdata_i[HW-1:0];
        hi_we[sn_park] = 1'b1;
        hi_d[sn_park]  = snap_wdata_i[DW-1:HW];
      end else begin
        lo_we[sn_pair] = 1'b1;
        lo_d[sn_pair]  = snap_wdata_i[HW-1:0];
        lo_we[sn_park] = 1'b1;
        lo_d[sn_park]  = snap_wdata_i[DW-1:HW];
      end
    end else if (!busy_i && wr_en_i) begin
      if (wide_i) begin
        lo_we[wr_idx_i] = 1'b1;
        lo_d[wr_idx_i]  = wr_data_i[HW-1:0];
        if (wr_dbl_i) begin
          hi_we[wr_idx_i] = 1'b1;
          hi_d[wr_idx_i]  = wr_data_i[DW-1:HW];
        end
      end else if (wr_dbl_i) begin
        lo_we[wr_pair] = 1'b1;
        hi_we[wr_pair] = 1'b1;
        lo_d[wr_pair]  = wr_data_i[HW-1:0];
        hi_d[wr_pair]  = wr_data_i[DW-1:HW];
      end else if (wr_idx_i[0]) begin
        hi_we[wr_pair] = 1'b1;
        hi_d[wr_pair]  = wr_data_i[HW-1:0];
      end else begin
        lo_we[wr_pair] = 1'b1;
        lo_d[wr_pair]  = wr_data_i[HW-1:0];
      end
    end
  end

  for (genvar w = 0; w < NW; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[w] <= '0;
      end else begin
        if (lo_we[w]) word_q[w][HW-1:0]  <= lo_d[w];
        if (hi_we[w]) word_q[w][DW-1:HW] <= hi_d[w];
      end
    end
  end

  // read views
  always_comb begin
    rd_pair      = {1'b0, rd_idx_i[IW-1:1]};
    rd_pair_word = word_q[rd_pair];
    rd_word      = word_q[rd_idx_i];
    if (wide_i) begin
      rd_double_o = rd_word;
      rd_single_o = rd_word[HW-1:0];
    end else begin
      rd_double_o = rd_pair_word;
      rd_single_o = rd_idx_i[0] ? rd_pair_word[DW-1:HW] : rd_pair_word[HW-1:0];
    end
  end

  always_comb begin
    sn_word      = word_q[snap_idx_i];
    sn_pair_word = word_q[sn_pair];
    sn_park_word = word_q[sn_park];
    if (wide_i) begin
      snap_rdata_o = sn_word;
    end else if (snap_idx_i[0]) begin
      snap_rdata_o = {sn_park_word[DW-1:HW], sn_pair_word[DW-1:HW]};
    end else begin
      snap_rdata_o = {sn_park_word[HW-1:0], sn_pair_word[HW-1:0]};
    end
  end

  assign words_o = word_q;

  AST_CAPTURE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (busy_i && !rp_we_i) |=> $stable(word_q)); // R9
  AST_PLACE_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n) rp_we_i |-> ($countones(lo_we) == 1)); // R8

endmodule

// File: rtl/dual_fpr_file.sv
module dual_fpr_file #(
  parameter int          LOG_WORDS    = 5,
  parameter int          HW           = 32,
  parameter int          SW           = 32,
  parameter int          MODE_BIT     = 26,
  parameter logic [31:0] RESET_STATUS = 32'h3400_0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 status_we,
  input  logic [SW-1:0]        status_wdata,
  output logic [SW-1:0]        status_q,
  output logic                 busy,
  input  logic [LOG_WORDS-1:0] rd_idx,
  output logic [HW-1:0]        rd_single,
  output logic [2*HW-1:0]      rd_double,
  input  logic                 wr_en,
  input  logic                 wr_dbl,
  input  logic [LOG_WORDS-1:0] wr_idx,
  input  logic [2*HW-1:0]      wr_data,
  input  logic [LOG_WORDS-1:0] snap_idx,
  output logic [2*HW-1:0]      snap_rdata,
  input  logic                 snap_we,
  input  logic [2*HW-1:0]      snap_wdata
);

  localparam int NW = 1 << LOG_WORDS;
  localparam int DW = 2 * HW;

  logic [1:0]            rst_sync_q;
  logic                  rst_n_int;
  logic                  wide;
  logic                  start;
  logic                  to_wide;
  logic                  rp_we;
  logic [LOG_WORDS-1:0]  rp_idx;
  logic [DW-1:0]         rp_wdata;
  logic [NW-1:0][DW-1:0] words;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  fpr_mode_ctl #(
    .SW(SW), .MODE_BIT(MODE_BIT), .RESET_STATUS(RESET_STATUS)
  ) i_mode (
    .clk(clk), .rst_n(rst_n_int),
    .status_we_i(status_we), .status_wdata_i(status_wdata), .busy_i(busy),
    .status_q_o(status_q), .wide_o(wide), .start_o(start), .to_wide_o(to_wide)
  );

  fpr_repack_seq #(.LOG_WORDS(LOG_WORDS), .HW(HW)) i_seq (
    .clk(clk), .rst_n(rst_n_int),
    .start_i(start), .to_wide_i(to_wide), .words_i(words),
    .busy_o(busy), .rp_we_o(rp_we), .rp_idx_o(rp_idx), .rp_wdata_o(rp_wdata)
  );

  fpr_store #(.LOG_WORDS(LOG_WORDS), .HW(HW)) i_store (
    .clk(clk), .rst_n(rst_n_int),
    .wide_i(wide), .busy_i(busy),
    .wr_en_i(wr_en), .wr_dbl_i(wr_dbl), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .snap_we_i(snap_we), .snap_idx_i(snap_idx), .snap_wdata_i(snap_wdata),
    .rp_we_i(rp_we), .rp_idx_i(rp_idx), .rp_wdata_i(rp_wdata),
    .rd_idx_i(rd_idx), .rd_single_o(rd_single), .rd_double_o(rd_double),
    .snap_rdata_o(snap_rdata), .words_o(words)
  );

  AST_SAME_MODE_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n_int) (status_we && !busy && (status_wdata[MODE_BIT] == status_q[MODE_BIT])) |=> !busy); // R6

endmodule

// File: tb/test_dual_fpr_file.sv
module test_dual_fpr_file;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        status_we = 1'b0;
  logic [31:0] status_wdata = '0;
  logic [31:0] status_q;
  logic        busy;
  logic [4:0]  rd_idx = '0;
  logic [31:0] rd_single;
  logic [63:0] rd_double;
  logic        wr_en = 1'b0;
  logic        wr_dbl = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [63:0] wr_data = '0;
  logic [4:0]  snap_idx = '0;
  logic [63:0] snap_rdata;
  logic        snap_we = 1'b0;
  logic [63:0] snap_wdata = '0;

  int nchk = 0;
  int nerr = 0;
  logic [63:0] model [32];
  bit wide = 1'b1;

  always #5 clk = ~clk;

  dual_fpr_file i_dual_fpr_file (
    .clk(clk), .rst_n(rst_n),
    .status_we(status_we), .status_wdata(status_wdata), .status_q(status_q), .busy(busy),
    .rd_idx(rd_idx), .rd_single(rd_single), .rd_double(rd_double),
    .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_idx(wr_idx), .wr_data(wr_data),
    .snap_idx(snap_idx), .snap_rdata(snap_rdata), .snap_we(snap_we), .snap_wdata(snap_wdata)
  );

  function automatic logic [63:0] pat(int i, int s);
    logic [31:0] a, b;
    a = 32'(i) * 32'h9E37_79B9 + 32'(s) * 32'h7F4A_7C15;
    b = ~(32'(i) * 32'h85EB_CA6B) ^ (32'(s) * 32'h1B87_3593);
    return {a, b};
  endfunction

  function automatic logic [63:0] exp_double(int i);
    int k;
    if (wide) return model[i];
    k = i & ~1;
    return {model[k+1][31:0], model[k][31:0]};
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(bit dbl, int idx, logic [63:0] d);
    int k;
    wr_en = 1'b1; wr_dbl = dbl; wr_idx = 5'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!dbl) model[idx][31:0] = d[31:0];
    else if (wide) model[idx] = d;
    else begin
      k = idx & ~1;
      model[k][31:0] = d[31:0];
      model[k+1][31:0] = d[63:32];
    end
  endtask

  task automatic snap_write(int idx, logic [63:0] d);
    snap_we = 1'b1; snap_idx = 5'(idx); snap_wdata = d;
    @(negedge clk);
    snap_we = 1'b0;
    model[idx] = d;
  endtask

  task automatic check_reg(int idx, string tag);
    logic [63:0] e;
    rd_idx = 5'(idx);
    #1;
    e = exp_double(idx);
    chk(rd_double == e, tag, rd_double, e);
    chk(rd_single == model[idx][31:0], tag, {32'h0, rd_single}, {32'h0, model[idx][31:0]});
  endtask

  task automatic check_snap(int idx, string tag);
    snap_idx = 5'(idx);
    #1;
    chk(snap_rdata == model[idx], tag, snap_rdata, model[idx]);
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 32; i++) begin
      check_reg(i, tag);
      check_snap(i, tag);
    end
  endtask

  // flip the mode, count busy cycles, optionally try writes during busy
  task automatic flip(logic [31:0] v, bit inject, string tag);
    int n;
    status_we = 1'b1; status_wdata = v;
    @(negedge clk);
    status_we = 1'b0;
    n = 0;
    while (busy) begin
      if (inject && n == 5) begin
        wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd0; wr_data = '1;
        snap_we = 1'b1; snap_idx = 5'd1; snap_wdata = 64'h5555_AAAA_5555_AAAA;
        status_we = 1'b1; status_wdata = ~v;
      end else begin
        wr_en = 1'b0; snap_we = 1'b0; status_we = 1'b0;
      end
      n++;
      @(negedge clk);
    end
    wr_en = 1'b0; snap_we = 1'b0; status_we = 1'b0;
    wide = v[26];
    chk(n == 64, {tag, " R9 busy length"}, 64'(n), 64'd64);
    chk(status_q == v, {tag, " R9 status"}, {32'h0, status_q}, {32'h0, v});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL R9 watchdog expired, busy stuck or run hung");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(status_q == 32'h3400_0000, "R1 status", {32'h0, status_q}, 64'h3400_0000);
    chk(busy == 1'b0, "R1 busy", {63'h0, busy}, 64'h0);
    check_all("R1 cleared");

    // R2 / R3: wide mode sweep
    for (int i = 0; i < 32; i++) reg_write(1'b1, i, pat(i, 1));
    for (int i = 0; i < 32; i++) check_reg(i, "R2 wide double");
    for (int i = 0; i < 32; i += 3) reg_write(1'b0, i, {32'hDEAD_0000, 32'(i) * 32'h1111_1111});
    for (int i = 0; i < 32; i++) check_reg(i, "R3 wide single keeps upper");

    // R6: status write without a mode change
    status_we = 1'b1; status_wdata = 32'h3400_0001;
    @(negedge clk);
    status_we = 1'b0;
    chk(busy == 1'b0, "R6 no busy", {63'h0, busy}, 64'h0);
    chk(status_q == 32'h3400_0001, "R6 status", {32'h0, status_q}, 64'h3400_0001);
    for (int i = 0; i < 32; i++) check_snap(i, "R6 contents kept");

    // R7 / R9: to narrow, with writes attempted while busy
    flip(32'h3000_0000, 1'b1, "to narrow");
    check_all("R7 R4 R5 R10 after narrowing");

    // R4 / R5 / R11: narrow-mode writes
    for (int i = 0; i < 32; i++) begin
      case (i % 4)
        0: reg_write(1'b1, i, pat(i, 2));
        1: reg_write(1'b1, i, pat(i, 4));
        2: reg_write(1'b0, i, pat(i, 5));
        default: ;
      endcase
    end
    check_all("R4 R5 narrow writes");
    snap_write(5, pat(5, 3));
    snap_write(20, pat(20, 3));
    snap_write(31, pat(31, 3));
    check_all("R11 R10 narrow snapshot");

    // R8: back to wide
    flip(32'h3400_0000, 1'b0, "to wide");
    check_all("R8 after widening");

    // R8: full round trip without writes
    flip(32'h3000_0000, 1'b0, "round narrow");
    flip(32'h3400_0000, 1'b0, "round wide");
    check_all("R8 round trip");

    // R11 / R12 in wide mode
    wr_en = 1'b1; wr_dbl = 1'b1; wr_idx = 5'd3; wr_data = 64'h0123_4567_89AB_CDEF;
    snap_we = 1'b1; snap_idx = 5'd9; snap_wdata = 64'hFEDC_BA98_7654_3210;
    @(negedge clk);
    wr_en = 1'b0; snap_we = 1'b0;
    model[9] = 64'hFEDC_BA98_7654_3210;
    check_reg(3, "R12 register write dropped");
    check_snap(9, "R11 R12 snapshot write");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule